// File: doc/BRIEF.md
# Wake Event Router

This block gathers up to twenty event lines from wake pins and on-chip peripherals and turns them into a single wake request. Each line is first brought into the local clock domain by a two-flop synchroniser. It is then detected either by level or by edge, with its own active polarity. A detected event is latched into a sticky status bit. The request output goes high when any status bit whose enable is set reads 1.

Software controls the block through a plain register bus. A polarity register and a detection-mode register are written directly. The enable and status registers are read-only at their own addresses. They change only through separate write-one-to-set and write-one-to-clear alias addresses, so one source can be updated without a read-modify-write of the others. Only bit positions 0 to 16 and 19 hold a source. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `wake_event_router`

## Requirements
- R1: Bits 17 and 18 have no source. In every register they read as 0, and writes to them, including status and enable alias writes, have no effect.
- R2: After reset, polarity, mode and enable read 0, status reads 1 in every implemented bit (0x9FFFF), and `wake_req` is 0.
- R3: The address map is: 0 polarity, 1 mode, 2 enable-set, 3 enable-clear, 4 status, 5 enable, 6 status-set, 7 status-clear. A read drives `bus_rdata` in the cycle after the read is presented. Polarity and mode keep what was last written in their implemented bits.
- R4: Writing 1 to a bit at enable-set sets that enable bit, and writing 1 at enable-clear clears it. Bits written as 0 keep their value.
- R5: Writing 1 to a bit at status-set forces that status bit to 1, and writing 1 at status-clear forces it to 0. Bits written as 0 keep their value.
- R6: With mode bit 0 (level), the status bit is set in every cycle that the synchronised input is at its active level. Polarity 1 means high is active and polarity 0 means low is active. While the input is inactive, a clear works.
- R7: With mode bit 1 (edge), a rising edge sets status when polarity is 1, and a falling edge sets it when polarity is 0. The bit stays set after the input returns, until it is cleared.
- R8: Inputs pass through a two-flop synchroniser. An edge presented between clock edges sets status on the third rising clock edge after the change, and not earlier.
- R9: When a detected event and a status-clear of the same bit occur in the same cycle, the bit ends up set.
- R10: `wake_req` is a register holding the OR of (status AND enable). It changes one clock after status or enable changes.
- R11: Reading any of the write-only alias addresses (2, 3, 6, 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 20 | Raw event lines, one per bit position |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Registered read data |
| wake_req | output | 1 | Combined wake request |

## Verification
The hardest case to reach is a hardware edge event and a status-clear write landing on the same bit in the same clock. The detection pulse lasts only one cycle, and it appears a fixed number of clocks behind the input because of the synchroniser. The stimulus raises the input on a falling clock edge and counts two clock edges. It then presents the clear write so that it is captured on exactly the edge that latches the event, and reads status back afterwards. The synchroniser latency is measured the same way, by watching `wake_req` edge by edge after a single input change with that source enabled.

// File: rtl/wer_pkg.sv
package wer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_POL    = 3'd0,
    A_MODE   = 3'd1,
    A_EN_SET = 3'd2,
    A_EN_CLR = 3'd3,
    A_STATUS = 3'd4,
    A_ENABLE = 3'd5,
    A_ST_SET = 3'd6,
    A_ST_CLR = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/wer_sync.sv
module wer_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] smp
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= raw[i];
        sync_q <= meta_q;
      end
    end
    assign smp[i] = sync_q;
  end
endmodule

// File: rtl/wer_detect.sv
module wer_detect #(
  parameter int           W    = 20,
  parameter logic [W-1:0] MASK = 20'h9FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mode,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] raw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    logic lvl_act, edge_act;
    always_comb begin
      lvl_act  = pol[i] ? smp[i] : ~smp[i];
      edge_act = pol[i] ? (smp[i] & ~prev_q[i]) : (~smp[i] & prev_q[i]);
      raw_hit[i] = mode[i] ? edge_act : lvl_act;
    end
  end

  assign hit = raw_hit & MASK;
endmodule

// File: rtl/wer_regs.sv
module wer_regs
  import wer_pkg::*;
#(
  parameter int           W    = 20,
  parameter logic [W-1:0] MASK = 20'h9FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      st_q,
  output logic [W-1:0]      en_q
);
  reg_addr_e    addr;
  logic         wr, rd;
  logic [W-1:0] st_nxt, en_nxt, rd_mux;

  assign addr = reg_addr_e'(bus_addr);
  assign wr   = bus_en & bus_we;
  assign rd   = bus_en & ~bus_we;

  always_comb begin
    en_nxt = en_q;
    if (wr && addr == A_EN_SET) en_nxt = en_nxt | bus_wdata;
    if (wr && addr == A_EN_CLR) en_nxt = en_nxt & ~bus_wdata;
    en_nxt = en_nxt & MASK;
  end

  // a hardware hit is ORed in last so it overrides a same-cycle clear
  always_comb begin
    st_nxt = st_q;
    if (wr && addr == A_ST_SET) st_nxt = st_nxt | bus_wdata;
    if (wr && addr == A_ST_CLR) st_nxt = st_nxt & ~bus_wdata;
    st_nxt = (st_nxt | hit) & MASK;
  end

  always_comb begin
    case (addr)
      A_POL:    rd_mux = pol_q;
      A_MODE:   rd_mux = mode_q;
      A_STATUS: rd_mux = st_q;
      A_ENABLE: rd_mux = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q     <= '0;
      mode_q    <= '0;
      en_q      <= '0;
      st_q      <= MASK;
      bus_rdata <= '0;
    end else begin
      if (wr && addr == A_POL)  pol_q  <= bus_wdata & MASK;
      if (wr && addr == A_MODE) mode_q <= bus_wdata & MASK;
      en_q <= en_nxt;
      st_q <= st_nxt;
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wake_event_router.sv
module wake_event_router
  import wer_pkg::*;
#(
  parameter int               EVT_W     = 20,
  parameter logic [EVT_W-1:0] IMPL_MASK = 20'h9FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [EVT_W-1:0]  bus_wdata,
  output logic [EVT_W-1:0]  bus_rdata,
  output logic              wake_req
);
  logic [EVT_W-1:0] smp, hit_w, pol_q, mode_q, st_q, en_q;

  wer_sync #(.W(EVT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(evt_in), .smp(smp)
  );

  wer_detect #(.W(EVT_W), .MASK(IMPL_MASK)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp), .pol(pol_q), .mode(mode_q), .hit(hit_w)
  );

  wer_regs #(.W(EVT_W), .MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hit(hit_w),
    .bus_rdata(bus_rdata), .pol_q(pol_q), .mode_q(mode_q),
    .st_q(st_q), .en_q(en_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= |(st_q & en_q);
  end
endmodule

// File: rtl/wer_checker.sv
module wer_checker
  import wer_pkg::*;
#(
  parameter int           W    = 20,
  parameter logic [W-1:0] MASK = 20'h9FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              wake_req,
  input logic [W-1:0]      status,
  input logic [W-1:0]      enable,
  input logic [W-1:0]      hit
);
  logic wr_ens, wr_enc, wr_sts, wr_stc;
  assign wr_ens = bus_en && bus_we && (bus_addr == A_EN_SET);
  assign wr_enc = bus_en && bus_we && (bus_addr == A_EN_CLR);
  assign wr_sts = bus_en && bus_we && (bus_addr == A_ST_SET);
  assign wr_stc = bus_en && bus_we && (bus_addr == A_ST_CLR);

  AST_RDATA_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~MASK) == '0); // R1
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ens |=> ((enable & $past(bus_wdata) & MASK) == ($past(bus_wdata) & MASK))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enc |=> ((enable & $past(bus_wdata)) == '0)); // R4
  AST_ST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((status & $past(bus_wdata) & MASK) == ($past(bus_wdata) & MASK))); // R5
  AST_ST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stc |=> ((status & $past(bus_wdata) & ~$past(hit)) == '0)); // R5
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit))); // R9
  AST_WAKE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) != '0) |=> wake_req); // R10
  AST_WAKE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |=> !wake_req); // R10
endmodule

bind wake_event_router wer_checker #(.W(EVT_W), .MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .wake_req(wake_req), .status(st_q), .enable(en_q), .hit(hit_w)
);

// File: tb/test_wake_event_router.sv
`timescale 1ns/1ps
module test_wake_event_router;
  localparam logic [19:0] MASK = 20'h9FFFF;
  localparam logic [2:0] A_POL = 3'd0, A_MODE = 3'd1, A_EN_SET = 3'd2, A_EN_CLR = 3'd3,
                         A_STATUS = 3'd4, A_ENABLE = 3'd5, A_ST_SET = 3'd6, A_ST_CLR = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] evt = 20'hFFFFF;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [19:0] bus_wdata = '0;
  logic [19:0] bus_rdata;
  logic        wake_req;
  logic        rd_due = 1'b0;
  int          checks = 0, failures = 0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  wake_event_router i_wake_event_router (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req)
  );

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%05h expected=0x%05h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // driver: pushes the expected read value for the monitor
  task automatic rd(input logic [2:0] a, input logic [19:0] e, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_due <= bus_en & ~bus_we;

  // monitor: compares registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_due && exp_q.size() > 0) begin
      logic [19:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk("R2 wake after reset", {19'd0, wake_req}, 20'd0);
    rd(A_STATUS, MASK,  "R2 status reset");
    rd(A_ENABLE, 20'd0, "R2 enable reset");
    rd(A_POL,    20'd0, "R2 polarity reset");
    rd(A_MODE,   20'd0, "R2 mode reset");
    idle(4);
    wr(A_MODE, 20'hFFFFF);
    rd(A_MODE, MASK, "R3 R1 mode readback");
    wr(A_POL, 20'hFFFFF);
    rd(A_POL, MASK, "R3 R1 polarity readback");
    rd(A_EN_SET, 20'd0, "R11 enable-set read");
    rd(A_ST_CLR, 20'd0, "R11 status-clear read");
    wr(A_ST_CLR, 20'hFFFFF);
    rd(A_STATUS, 20'd0, "R5 clear all");

    // R8 / R10: latency from input edge to wake_req
    wr(A_EN_SET, 20'h00004);
    evt[2] = 1'b0;
    idle(4);
    rd(A_STATUS, 20'd0, "R7 falling edge ignored with polarity 1");
    evt[2] = 1'b1;
    @(negedge clk); chk("R8 edge1", {19'd0, wake_req}, 20'd0);
    @(negedge clk); chk("R8 edge2", {19'd0, wake_req}, 20'd0);
    @(negedge clk); chk("R8 edge3", {19'd0, wake_req}, 20'd0);
    @(negedge clk); chk("R10 edge4", {19'd0, wake_req}, 20'd1);
    evt[2] = 1'b0;
    idle(4);
    rd(A_STATUS, 20'h00004, "R7 edge sticky");
    rd(A_ENABLE, 20'h00004, "R4 enable set");
    wr(A_EN_CLR, 20'h00004);
    idle(1);
    chk("R4 R10 wake drops after enable clear", {19'd0, wake_req}, 20'd0);
    wr(A_EN_SET, 20'h60000);
    rd(A_ENABLE, 20'd0, "R1 unimplemented enable ignored");

    // falling edge with polarity 0 on bit 5
    wr(A_POL, 20'h9FFDF);
    evt[5] = 1'b0;
    idle(4);
    rd(A_STATUS, 20'h00024, "R7 falling edge polarity 0");

    // level mode on bit 19, active high
    wr(A_MODE, 20'h1FFFF);
    idle(4);
    wr(A_ST_CLR, 20'h80000);
    rd(A_STATUS, 20'h80024, "R6 R9 level active blocks clear");
    evt[19] = 1'b0;
    idle(4);
    wr(A_ST_CLR, 20'h80000);
    rd(A_STATUS, 20'h00024, "R6 level inactive clears");
    // level active low
    wr(A_POL, 20'h1FFDF);
    idle(4);
    rd(A_STATUS, 20'h80024, "R6 level active low");
    evt[19] = 1'b1;
    idle(4);
    wr(A_ST_CLR, 20'h80000);
    rd(A_STATUS, 20'h00024, "R6 level active low released");

    // R9: edge detection and clear in the same cycle on bit 0
    evt[0] = 1'b0;
    idle(4);
    evt[0] = 1'b1;
    @(negedge clk);
    wr(A_ST_CLR, 20'h00001);
    rd(A_STATUS, 20'h00025, "R9 event wins over clear");

    wr(A_ST_SET, 20'h60400);
    rd(A_STATUS, 20'h00425, "R5 R1 status set");
    wr(A_ST_CLR, 20'h00425);
    rd(A_STATUS, 20'd0, "R5 status clear");

    // R10: one-cycle latency of wake_req
    wr(A_EN_SET, 20'h00001);
    wr(A_ST_SET, 20'h00001);
    chk("R10 not yet", {19'd0, wake_req}, 20'd0);
    @(negedge clk);
    chk("R10 one cycle later", {19'd0, wake_req}, 20'd1);
    wr(A_ST_CLR, 20'h00001);
    idle(1);
    chk("R10 drops", {19'd0, wake_req}, 20'd0);
    rd(A_ENABLE, 20'h00001, "R4 enable holds");
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule